// File: doc/BRIEF.md
# Isochronous Cycle Timer with Cycle-Start Trigger

This block keeps the serial-bus cycle time that isochronous scheduling is based on. A sub-cycle offset counter runs from a 24.576 MHz reference. The offset wraps once per 125 µs isochronous cycle, which is an 8 kHz rate. Each wrap advances a cycle count, and each wrap of the cycle count advances a seconds field. The host can overwrite all three fields at once.

When the node acts as cycle master, every cycle boundary raises a cycle-start request toward the link transmitter. That request stays up until the transmitter acknowledges it. A control bit can move the boundary from the internal count to an external 8 kHz strobe, but only while the node is cycle master. In that mode the offset parks at its last value until the synchronised strobe edge arrives. Two one-clock interrupt pulses tell host software about cycle starts and about seconds rollovers.

Top module: `iso_cycle_timer`

## Requirements
- R1: While reset is high, and after it, the offset, cycle count, seconds, start request, lost flag and both interrupt outputs are all zero.
- R2: With no write pending, the offset rises by one per clock. From OFFSET_MAX (default 3071) it wraps to 0 and the cycle count advances. The cycle count wraps from CYCLE_MAX (default 7999) to 0 and the seconds field advances. Seconds wrap modulo 2^SEC_W.
- R3: A host write (`wr_en` high) loads seconds, cycle and offset together on one clock. It overrides the increment and any boundary on that clock, so that clock produces no boundary event.
- R4: In strobe mode (`cyc_master` and `ext_src_sel` both 1), the offset holds at OFFSET_MAX. The boundary occurs on the third rising clock edge after `ext_strobe` first goes high (two synchroniser flops plus edge detection). Only a rising edge of the strobe counts.
- R5: In strobe mode, a strobe edge that arrives while the offset is below OFFSET_MAX forces a boundary at once, with the same latency as R4.
- R6: When `cyc_master` is 0, `ext_src_sel` and `ext_strobe` have no effect: the offset keeps wrapping by itself, and no start request or cycle-start interrupt is raised.
- R7: A boundary while `cyc_master` is 1 sets `start_req` on that clock edge. `start_req` stays high until a clock on which `start_ack` is high, and it clears on that clock unless a new boundary happens on the same clock.
- R8: A boundary while `start_req` is already high and `start_ack` is low sets `lost_cycle`. Only reset clears it.
- R9: `irq_cycle_start` is a one-clock pulse that comes with each boundary while cycle master, and it rises together with `start_req`.
- R10: `irq_seconds` is a one-clock pulse on each boundary that wraps the cycle count, whether or not the node is cycle master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24.576 MHz timer reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_master | input | 1 | Node is cycle master |
| ext_src_sel | input | 1 | 1 = boundaries come from the external strobe (only honoured as master) |
| ext_strobe | input | 1 | Asynchronous 8 kHz cycle strobe |
| wr_en | input | 1 | Host write of the timer value |
| wr_seconds | input | SEC_W | Seconds value to load |
| wr_cycle | input | clog2(CYCLE_MAX+1) | Cycle count to load |
| wr_offset | input | clog2(OFFSET_MAX+1) | Offset to load |
| start_ack | input | 1 | Transmitter accepted the cycle-start request |
| time_seconds | output | SEC_W | Seconds field |
| time_cycle | output | clog2(CYCLE_MAX+1) | Cycle count |
| time_offset | output | clog2(OFFSET_MAX+1) | Sub-cycle offset |
| start_req | output | 1 | Cycle-start request to the link transmitter |
| lost_cycle | output | 1 | Sticky: a boundary hit an unacknowledged request |
| irq_cycle_start | output | 1 | One-clock cycle-start interrupt |
| irq_seconds | output | 1 | One-clock seconds-rollover interrupt |

## Verification
All outputs are registered. A write, an increment or an internal boundary is therefore visible one clock after the edge that samples the stimulus. A rising strobe shows its effect only after the third clock edge, because the two synchroniser flops and the edge register come first. The bench changes inputs on falling edges and samples on a later falling edge, after exactly the number of rising edges each result needs. It checks the count just before the due edge as well as on it, so a result that arrives one clock early or late is caught. A scaled-down wrap (8 offsets, 4 cycles, 3-bit seconds) makes the wrap order, the source switching and the pulse widths reachable in a few hundred clocks.

// File: rtl/iso_timer_pkg.sv
package iso_timer_pkg;

  // Which event ends a cycle.
  typedef enum logic [0:0] {
    SRC_COUNTER = 1'b0,
    SRC_STROBE  = 1'b1
  } cyc_src_e;

  // Number of synchroniser flops ahead of the edge detector.
  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/strobe_edge_sync.sv
module strobe_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic rise_pulse
);

  // sync_q[STAGES-1] is the synchronised level; sync_q[STAGES] is its delayed copy.
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-1:0], strobe_in};
    end
  end

  assign rise_pulse = sync_q[STAGES-1] & ~sync_q[STAGES];

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |=> !rise_pulse); // R4

endmodule

// File: rtl/cycle_time_counter.sv
module cycle_time_counter #(
  parameter int unsigned OFFSET_MAX = 3071,
  parameter int unsigned CYCLE_MAX  = 7999,
  parameter int unsigned SEC_W      = 7,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned CYC_W      = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEC_W-1:0] wr_sec,
  input  logic [CYC_W-1:0] wr_cyc,
  input  logic [OFF_W-1:0] wr_off,
  input  logic             strobe_mode,
  input  logic             strobe_rise,
  output logic [SEC_W-1:0] sec_q,
  output logic [CYC_W-1:0] cyc_q,
  output logic [OFF_W-1:0] off_q,
  output logic             boundary,
  output logic             sec_roll
);

  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFFSET_MAX);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYCLE_MAX);

  logic off_at_last;
  logic cyc_at_last;

  assign off_at_last = (off_q == OFF_LAST);
  assign cyc_at_last = (cyc_q == CYC_LAST);

  // A cycle ends at the counter wrap (counter mode) or at a strobe edge
  // (strobe mode). A host write on the same clock takes precedence.
  always_comb begin
    if (wr_en) begin
      boundary = 1'b0;
    end else if (strobe_mode) begin
      boundary = strobe_rise;
    end else begin
      boundary = off_at_last;
    end
  end

  assign sec_roll = boundary & cyc_at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= '0;
      cyc_q <= '0;
      sec_q <= '0;
    end else if (wr_en) begin
      off_q <= wr_off;
      cyc_q <= wr_cyc;
      sec_q <= wr_sec;
    end else if (boundary) begin
      off_q <= '0;
      cyc_q <= cyc_at_last ? '0 : cyc_q + CYC_W'(1);
      if (cyc_at_last) begin
        sec_q <= sec_q + SEC_W'(1);
      end
    end else if (!off_at_last) begin
      off_q <= off_q + OFF_W'(1);
    end
    // otherwise: strobe mode parked at the last offset
  end

  AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !strobe_rise && !off_at_last) |=> (off_q == $past(off_q) + OFF_W'(1))); // R2

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (off_q == $past(wr_off) && cyc_q == $past(wr_cyc) && sec_q == $past(wr_sec))); // R3

  AST_STROBE_PARK: assert property (@(posedge clk) disable iff (rst)
    (strobe_mode && off_at_last && !strobe_rise && !wr_en) |=> (off_q == OFF_LAST)); // R4

  AST_CYCLE_HELD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !boundary) |=> $stable(cyc_q)); // R2

endmodule

// File: rtl/cycle_start_ctrl.sv
module cycle_start_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic master,
  input  logic boundary,
  input  logic sec_roll,
  input  logic ack,
  output logic req_q,
  output logic lost_q,
  output logic irq_cyc_q,
  output logic irq_sec_q
);

  logic new_start;

  assign new_start = boundary & master;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= 1'b0;
      lost_q    <= 1'b0;
      irq_cyc_q <= 1'b0;
      irq_sec_q <= 1'b0;
    end else begin
      irq_cyc_q <= new_start;
      irq_sec_q <= sec_roll;
      if (new_start) begin
        req_q <= 1'b1;
        if (req_q && !ack) begin
          lost_q <= 1'b1;
        end
      end else if (ack) begin
        req_q <= 1'b0;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_q && !ack) |=> req_q); // R7

  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (rst)
    lost_q |=> lost_q); // R8

  AST_IRQ_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    irq_cyc_q |-> req_q); // R9

  AST_IRQ_MASTER_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!master && !req_q && !ack) |=> !irq_cyc_q || $past(boundary)); // R6

endmodule

// File: rtl/iso_cycle_timer.sv
module iso_cycle_timer
  import iso_timer_pkg::*;
#(
  parameter int unsigned OFFSET_MAX = 3071,
  parameter int unsigned CYCLE_MAX  = 7999,
  parameter int unsigned SEC_W      = 7
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 cyc_master,
  input  logic                                 ext_src_sel,
  input  logic                                 ext_strobe,
  input  logic                                 wr_en,
  input  logic [SEC_W-1:0]                     wr_seconds,
  input  logic [$clog2(CYCLE_MAX+1)-1:0]       wr_cycle,
  input  logic [$clog2(OFFSET_MAX+1)-1:0]      wr_offset,
  input  logic                                 start_ack,
  output logic [SEC_W-1:0]                     time_seconds,
  output logic [$clog2(CYCLE_MAX+1)-1:0]       time_cycle,
  output logic [$clog2(OFFSET_MAX+1)-1:0]      time_offset,
  output logic                                 start_req,
  output logic                                 lost_cycle,
  output logic                                 irq_cycle_start,
  output logic                                 irq_seconds
);

  localparam int unsigned OFF_W = $clog2(OFFSET_MAX + 1);
  localparam int unsigned CYC_W = $clog2(CYCLE_MAX + 1);

  cyc_src_e src_sel;
  logic     strobe_mode;
  logic     strobe_rise;
  logic     boundary;
  logic     sec_roll;

  // The external source is only honoured while this node is cycle master.
  assign src_sel     = cyc_src_e'(ext_src_sel);
  assign strobe_mode = cyc_master && (src_sel == SRC_STROBE);

  strobe_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk        (clk),
    .rst        (rst),
    .strobe_in  (ext_strobe),
    .rise_pulse (strobe_rise)
  );

  cycle_time_counter #(
    .OFFSET_MAX (OFFSET_MAX),
    .CYCLE_MAX  (CYCLE_MAX),
    .SEC_W      (SEC_W),
    .OFF_W      (OFF_W),
    .CYC_W      (CYC_W)
  ) u_count (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_sec      (wr_seconds),
    .wr_cyc      (wr_cycle),
    .wr_off      (wr_offset),
    .strobe_mode (strobe_mode),
    .strobe_rise (strobe_rise),
    .sec_q       (time_seconds),
    .cyc_q       (time_cycle),
    .off_q       (time_offset),
    .boundary    (boundary),
    .sec_roll    (sec_roll)
  );

  cycle_start_ctrl u_start (
    .clk       (clk),
    .rst       (rst),
    .master    (cyc_master),
    .boundary  (boundary),
    .sec_roll  (sec_roll),
    .ack       (start_ack),
    .req_q     (start_req),
    .lost_q    (lost_cycle),
    .irq_cyc_q (irq_cycle_start),
    .irq_sec_q (irq_seconds)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (time_offset == '0 && time_cycle == '0 && time_seconds == '0 &&
             !start_req && !lost_cycle && !irq_cycle_start && !irq_seconds)); // R1

  AST_SEC_IRQ_WRAP: assert property (@(posedge clk) disable iff (rst)
    irq_seconds |-> (time_cycle == '0 && time_offset == '0)); // R10

endmodule

// File: tb/sim_iso_cycle_timer.sv
module sim_iso_cycle_timer;

  localparam int CLK_PERIOD = 10;
  localparam int OFFSET_MAX = 7;
  localparam int CYCLE_MAX  = 3;
  localparam int SEC_W      = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_master = 1'b0;
  logic       ext_src_sel = 1'b0;
  logic       ext_strobe = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_seconds = '0;
  logic [1:0] wr_cycle = '0;
  logic [2:0] wr_offset = '0;
  logic       start_ack = 1'b0;
  logic [2:0] time_seconds;
  logic [1:0] time_cycle;
  logic [2:0] time_offset;
  logic       start_req;
  logic       lost_cycle;
  logic       irq_cycle_start;
  logic       irq_seconds;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  iso_cycle_timer #(
    .OFFSET_MAX (OFFSET_MAX),
    .CYCLE_MAX  (CYCLE_MAX),
    .SEC_W      (SEC_W)
  ) u0 (
    .clk             (clk),
    .rst             (rst),
    .cyc_master      (cyc_master),
    .ext_src_sel     (ext_src_sel),
    .ext_strobe      (ext_strobe),
    .wr_en           (wr_en),
    .wr_seconds      (wr_seconds),
    .wr_cycle        (wr_cycle),
    .wr_offset       (wr_offset),
    .start_ack       (start_ack),
    .time_seconds    (time_seconds),
    .time_cycle      (time_cycle),
    .time_offset     (time_offset),
    .start_req       (start_req),
    .lost_cycle      (lost_cycle),
    .irq_cycle_start (irq_cycle_start),
    .irq_seconds     (irq_seconds)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_time(input string tag, input int s, input int c, input int o);
    check({tag, " seconds"}, int'(time_seconds), s);
    check({tag, " cycle"},   int'(time_cycle),   c);
    check({tag, " offset"},  int'(time_offset),  o);
  endtask

  task automatic host_write(input int s, input int c, input int o);
    wr_en = 1'b1; wr_seconds = 3'(s); wr_cycle = 2'(c); wr_offset = 3'(o);
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc_master = 1'b0; ext_src_sel = 1'b0; ext_strobe = 1'b0;
    wr_en = 1'b0; start_ack = 1'b0;
    step(3);
    check_time("R1 reset", 0, 0, 0);
    check("R1 start_req", int'(start_req), 0);
    check("R1 lost_cycle", int'(lost_cycle), 0);
    check("R1 irqs", int'(irq_cycle_start) + int'(irq_seconds), 0);
    rst = 1'b0;
  endtask

  task automatic t_free_run();
    step(5);
    check_time("R2 count", 0, 0, 5);
    step(2);
    check_time("R2 before wrap", 0, 0, 7);
    step(1);
    check_time("R2 wrap", 0, 1, 0);
    check("R6 no request when not master", int'(start_req), 0);
  endtask

  task automatic t_write_and_seconds();
    host_write(2, 3, 7);
    check_time("R3 load", 2, 3, 7);
    check("R10 no irq on load", int'(irq_seconds), 0);
    step(1);
    check_time("R2 cycle wrap", 3, 0, 0);
    check("R10 irq_seconds pulse", int'(irq_seconds), 1);
    step(1);
    check("R10 irq_seconds one clock", int'(irq_seconds), 0);
    host_write(7, 3, 7);
    step(1);
    check_time("R2 seconds modulo", 0, 0, 0);
    check("R10 irq on seconds wrap", int'(irq_seconds), 1);
    // write on a clock that would otherwise be a boundary
    host_write(0, 3, 6);
    step(1);
    check_time("R2 pre-boundary", 0, 3, 7);
    host_write(1, 2, 4);
    check_time("R3 write beats boundary", 1, 2, 4);
    check("R3 no boundary irq", int'(irq_seconds), 0);
  endtask

  task automatic t_master_requests();
    cyc_master = 1'b1;
    host_write(0, 0, 6);
    step(1);
    check("R7 no early request", int'(start_req), 0);
    step(1);
    check_time("R7 boundary", 0, 1, 0);
    check("R7 start_req set", int'(start_req), 1);
    check("R9 irq_cycle_start pulse", int'(irq_cycle_start), 1);
    step(1);
    check("R9 irq one clock", int'(irq_cycle_start), 0);
    check("R7 request held", int'(start_req), 1);
    start_ack = 1'b1;
    step(1);
    start_ack = 1'b0;
    check("R7 request cleared by ack", int'(start_req), 0);
    check("R8 no loss when acked", int'(lost_cycle), 0);
    step(6);
    check("R7 next request", int'(start_req), 1);
    check_time("R7 next boundary", 0, 2, 0);
    step(8);
    check("R8 lost on unacked boundary", int'(lost_cycle), 1);
    start_ack = 1'b1;
    step(1);
    start_ack = 1'b0;
    check("R8 lost sticky after ack", int'(lost_cycle), 1);
    check("R7 cleared", int'(start_req), 0);
    do_reset();
    check("R8 lost cleared by reset", int'(lost_cycle), 0);
  endtask

  task automatic t_strobe_source();
    cyc_master = 1'b1; ext_src_sel = 1'b1;
    host_write(0, 0, 5);
    step(2);
    check_time("R4 reach last", 0, 0, 7);
    step(10);
    check_time("R4 parked", 0, 0, 7);
    check("R4 no request while parked", int'(start_req), 0);
    ext_strobe = 1'b1;
    step(2);
    check_time("R4 still parked in sync", 0, 0, 7);
    step(1);
    check_time("R4 strobe boundary", 0, 1, 0);
    check("R4 request from strobe", int'(start_req), 1);
    start_ack = 1'b1; ext_strobe = 1'b0;
    step(1);
    start_ack = 1'b0;
    check_time("R4 restart", 0, 1, 1);
    ext_strobe = 1'b1;
    step(2);
    check_time("R5 before forced", 0, 1, 3);
    step(1);
    check_time("R5 early strobe forces boundary", 0, 2, 0);
    check("R5 irq on forced boundary", int'(irq_cycle_start), 1);
    step(4);
    check_time("R4 level gives no second edge", 0, 2, 4);
  endtask

  task automatic t_not_master();
    ext_strobe = 1'b0; cyc_master = 1'b0; ext_src_sel = 1'b1; start_ack = 1'b1;
    host_write(0, 0, 5);
    start_ack = 1'b0;
    check("R7 cleared before test", int'(start_req), 0);
    step(3);
    check_time("R6 wraps without strobe", 0, 1, 0);
    check("R6 no request", int'(start_req), 0);
    check("R6 no cycle irq", int'(irq_cycle_start), 0);
    ext_strobe = 1'b1;
    step(3);
    check_time("R6 strobe ignored", 0, 1, 3);
    ext_strobe = 1'b0;
  endtask

  initial begin
    step(1);
    do_reset();
    t_free_run();
    t_write_and_seconds();
    t_master_requests();
    t_strobe_source();
    t_not_master();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule